// File: doc/BRIEF.md
# Programmable Video Sync Generator

This block derives horizontal and vertical sync timing from the pixel clock. Four run-time values set the timing. The line period and the H pulse width are counted in pixel clocks. The frame period and the V pulse width are counted in lines. Each axis has its own polarity bit, an optional gate, and an optional armed start. The gate and the armed start each use one of three external qualifier inputs: event, strobe or trigger. A type field can also produce a composite sync by combining the two pulses with AND, OR or XOR.

The qualifier inputs are asynchronous to the pixel clock, so each passes through two flops before use. An armed start waits for a rising edge on the selected qualifier. That start condition is re-armed only by reset or by taking the enable low and high again. While the enable is low, nothing counts and every output rests at its inactive level.

Top module: `sync_gen`

## Requirements
- R1: With the H axis running, the H pulse is active for the first `h_width` pixel clocks of every line of `h_total` clocks. A line starts in the first cycle after the axis starts.
- R2: The V line count advances only at the start of each H line, so V pulse edges line up with H leading edges. The V pulse is active for the first `v_width` lines of every frame of `v_total` lines.
- R3: When a polarity bit is 1, that output is high while active. When it is 0, the output is low while active. The inactive level is the opposite of the active level.
- R4: `hsync_o` and `vsync_o` always carry the separate gated pulses. `csync_o` depends on `sync_type`. Code 0 holds it inactive. Code 1 gives H AND V, code 2 gives H OR V, and code 3 gives H XOR V. The combination uses active-high gated pulses, and the result takes its sense from `h_pol`.
- R5: Gate select codes are 0 = none, 1 = `ext_evt`, 2 = `ext_strb` and 3 = `ext_trig`. With a gate selected, the pulse on that axis is active only while the synchronized qualifier is high. A qualifier change reaches the outputs after two clock edges.
- R6: A start select of 0 starts the axis at the first clock edge with enable high. Codes 1, 2 and 3 use the same input mapping as R5. With one of them, the axis stays inactive until a rising edge of that qualifier. The first line then begins after the third clock edge following the input's rise.
- R7: With `en` low, both axes stop and every output is inactive from the next edge on, whatever the qualifiers do. On re-enable, an armed start again waits for a new rising edge; a qualifier that is already high does not start it.
- R8: A width of 0 never produces a pulse. A width equal to or above the period keeps that axis active all the time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Block enable |
| sync_type | input | 2 | Composite select: 0 off, 1 AND, 2 OR, 3 XOR |
| h_pol | input | 1 | H sense (1 = active high); also composite sense |
| v_pol | input | 1 | V sense (1 = active high) |
| h_gate_sel | input | 2 | H gate source |
| v_gate_sel | input | 2 | V gate source |
| h_start_sel | input | 2 | H start source |
| v_start_sel | input | 2 | V start source |
| h_total | input | HW | Line period in pixel clocks |
| h_width | input | HW | H pulse width in pixel clocks |
| v_total | input | VW | Frame period in lines |
| v_width | input | VW | V pulse width in lines |
| ext_evt | input | 1 | Qualifier input, code 1 |
| ext_strb | input | 1 | Qualifier input, code 2 |
| ext_trig | input | 1 | Qualifier input, code 3 |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| csync_o | output | 1 | Composite sync |

## Verification
A vector table sweeps the timing values, polarity pairs and all four composite codes. Every cycle of two full frames is compared with a pulse model derived from the elapsed cycle count. This separates AND from OR from XOR and checks the sense applied to each output. It also covers the zero-width and full-width cases.

Directed runs toggle the strobe and event gates in the middle of a frame to check the two-edge gate latency. An armed trigger start checks the three-edge start delay. Dropping and restoring the enable with the trigger already high shows that a level alone does not restart an armed axis.

// File: rtl/sync_gen.sv
module sync_gen #(
  parameter int HW = 12,
  parameter int VW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [1:0]    sync_type,
  input  logic          h_pol,
  input  logic          v_pol,
  input  logic [1:0]    h_gate_sel,
  input  logic [1:0]    v_gate_sel,
  input  logic [1:0]    h_start_sel,
  input  logic [1:0]    v_start_sel,
  input  logic [HW-1:0] h_total,
  input  logic [HW-1:0] h_width,
  input  logic [VW-1:0] v_total,
  input  logic [VW-1:0] v_width,
  input  logic          ext_evt,
  input  logic          ext_strb,
  input  logic          ext_trig,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          csync_o
);

  logic [2:0]    q_m, q_s, q_d;
  logic          h_run, v_run, v_armed;
  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  logic          h_go, v_go, h_gate, v_gate, h_last, v_last, line_start;
  logic          hp, vp, cp;
  logic [2:0]    q_rise;

  function automatic logic pick(input logic [1:0] sel, input logic [2:0] v);
    case (sel)
      2'd1:    pick = v[0];
      2'd2:    pick = v[1];
      2'd3:    pick = v[2];
      default: pick = 1'b1;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_m <= '0;
      q_s <= '0;
      q_d <= '0;
    end else begin
      q_m <= {ext_trig, ext_strb, ext_evt};
      q_s <= q_m;
      q_d <= q_s;
    end
  end

  assign q_rise     = q_s & ~q_d;
  assign h_go       = pick(h_start_sel, q_rise);
  assign v_go       = pick(v_start_sel, q_rise);
  assign h_gate     = pick(h_gate_sel, q_s);
  assign v_gate     = pick(v_gate_sel, q_s);
  assign h_last     = h_cnt >= h_total - HW'(1);
  assign v_last     = v_cnt >= v_total - VW'(1);
  assign line_start = h_run ? h_last : h_go;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      h_run <= 1'b0;
      h_cnt <= '0;
    end else if (!h_run) begin
      if (h_go) h_run <= 1'b1;
      h_cnt <= '0;
    end else begin
      h_cnt <= h_last ? '0 : h_cnt + HW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      v_run   <= 1'b0;
      v_armed <= 1'b0;
      v_cnt   <= '0;
    end else begin
      if (!v_run && v_go) v_armed <= 1'b1;
      if (line_start) begin
        if (v_run) begin
          v_cnt <= v_last ? '0 : v_cnt + VW'(1);
        end else if (v_armed || v_go) begin
          v_run <= 1'b1;
          v_cnt <= '0;
        end
      end
    end
  end

  assign hp = h_run && (h_cnt < h_width) && h_gate;
  assign vp = v_run && (v_cnt < v_width) && v_gate;

  always_comb begin
    case (sync_type)
      2'd1:    cp = hp & vp;
      2'd2:    cp = hp | vp;
      2'd3:    cp = hp ^ vp;
      default: cp = 1'b0;
    endcase
  end

  assign hsync_o = hp ^ ~h_pol;
  assign vsync_o = vp ^ ~v_pol;
  assign csync_o = cp ^ ~h_pol;

endmodule

module sync_gen_chk #(
  parameter int HW = 12,
  parameter int VW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [1:0]    sync_type,
  input logic          h_pol,
  input logic          v_pol,
  input logic          hsync_o,
  input logic          vsync_o,
  input logic          csync_o,
  input logic [HW-1:0] h_cnt,
  input logic [VW-1:0] v_cnt
);

  logic ha, va, ca;
  assign ha = (hsync_o == h_pol);
  assign va = (vsync_o == v_pol);
  assign ca = (csync_o == h_pol);

  assert_idle_inactive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!en -> (!ha && !va && !ca)));

  assert_comp_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_type == 2'd0 |-> !ca);

  assert_comp_and_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_type == 2'd1 |-> ca == (ha && va));

  assert_comp_or_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_type == 2'd2 |-> ca == (ha || va));

  assert_comp_xor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_type == 2'd3 |-> ca == (ha ^ va));

  assert_v_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(v_cnt) |-> h_cnt == '0);

endmodule

bind sync_gen sync_gen_chk #(.HW(HW), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .sync_type(sync_type),
  .h_pol(h_pol), .v_pol(v_pol), .hsync_o(hsync_o), .vsync_o(vsync_o),
  .csync_o(csync_o), .h_cnt(h_cnt), .v_cnt(v_cnt)
);

// File: tb/sync_gen_tb.sv
`timescale 1ns/1ps
module sync_gen_tb;
  localparam int HW = 12;
  localparam int VW = 12;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [1:0] sync_type = 2'd0, h_gate_sel = 2'd0, v_gate_sel = 2'd0;
  logic [1:0] h_start_sel = 2'd0, v_start_sel = 2'd0;
  logic h_pol = 1'b0, v_pol = 1'b0;
  logic [HW-1:0] h_total = 12'd10, h_width = 12'd3;
  logic [VW-1:0] v_total = 12'd4, v_width = 12'd1;
  logic ext_evt = 1'b0, ext_strb = 1'b0, ext_trig = 1'b0;
  logic hsync_o, vsync_o, csync_o;

  int checks = 0, errors = 0, t = 0;
  logic gh = 1'b1, gv = 1'b1;

  always #2 clk = ~clk;

  sync_gen #(.HW(HW), .VW(VW)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .sync_type(sync_type),
    .h_pol(h_pol), .v_pol(v_pol), .h_gate_sel(h_gate_sel), .v_gate_sel(v_gate_sel),
    .h_start_sel(h_start_sel), .v_start_sel(v_start_sel),
    .h_total(h_total), .h_width(h_width), .v_total(v_total), .v_width(v_width),
    .ext_evt(ext_evt), .ext_strb(ext_strb), .ext_trig(ext_trig),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .csync_o(csync_o)
  );

  // {type, hpol, vpol, htotal, hwidth, vtotal, vwidth}
  localparam logic [35:0] VEC [6] = '{
    {2'd0, 1'b0, 1'b0, 8'd10, 8'd3, 8'd4, 8'd1},
    {2'd1, 1'b1, 1'b1, 8'd8,  8'd2, 8'd3, 8'd2},
    {2'd2, 1'b0, 1'b1, 8'd7,  8'd3, 8'd5, 8'd2},
    {2'd3, 1'b1, 1'b0, 8'd6,  8'd2, 8'd3, 8'd1},
    {2'd0, 1'b1, 1'b1, 8'd5,  8'd0, 8'd3, 8'd3},
    {2'd2, 1'b1, 1'b0, 8'd4,  8'd4, 8'd2, 8'd1}
  };

  task automatic chk(input string r, input string sig, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s t=%0d actual=%b expected=%b", r, sig, t, act, exp);
    end
  endtask

  task automatic check_model(input string r);
    int ht, hw, vt, vw, line;
    logic ph, pv, c;
    ht = int'(h_total); hw = int'(h_width); vt = int'(v_total); vw = int'(v_width);
    line = t / ht;
    ph = ((t % ht) < hw) && gh;
    pv = ((line % vt) < vw) && gv;
    case (sync_type)
      2'd1: c = ph & pv;
      2'd2: c = ph | pv;
      2'd3: c = ph ^ pv;
      default: c = 1'b0;
    endcase
    chk(r, "hsync", hsync_o, h_pol ? ph : !ph);
    chk(r, "vsync", vsync_o, v_pol ? pv : !pv);
    chk(r, "csync", csync_o, h_pol ? c : !c);
  endtask

  task automatic check_idle(input string r);
    chk(r, "hsync", hsync_o, !h_pol);
    chk(r, "vsync", vsync_o, !v_pol);
    chk(r, "csync", csync_o, !h_pol);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    t++;
  endtask

  task automatic start_now();
    en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    t = 0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    en = 1'b1;
    repeat (3) @(negedge clk);
    check_idle("R3 reset");
    rst_n = 1'b1;
    en = 1'b0;
    tick();
    check_idle("R7 idle after reset");

    foreach (VEC[i]) begin
      {sync_type, h_pol, v_pol} = VEC[i][35:32];
      h_total = HW'(VEC[i][31:24]);
      h_width = HW'(VEC[i][23:16]);
      v_total = VW'(VEC[i][15:8]);
      v_width = VW'(VEC[i][7:0]);
      gh = 1'b1; gv = 1'b1;
      start_now();
      for (int k = 0; k < 2 * int'(h_total) * int'(v_total); k++) begin
        check_model("R1 R2 R3 R4 R8 table");
        tick();
      end
      en = 1'b0;
      tick();
      check_idle("R7 disable");
    end

    // R5 gating: H on strobe, V on event
    sync_type = 2'd2; h_pol = 1'b1; v_pol = 1'b0;
    h_total = 12'd6; h_width = 12'd3; v_total = 12'd3; v_width = 12'd1;
    h_gate_sel = 2'd2; v_gate_sel = 2'd1;
    gh = 1'b0; gv = 1'b0;
    start_now();
    for (int k = 0; k < 18; k++) begin check_model("R5 gated off"); tick(); end
    ext_strb = 1'b1;
    tick(); check_model("R5 strobe not yet seen");
    tick(); gh = 1'b1;
    for (int k = 0; k < 18; k++) begin check_model("R5 strobe gate"); tick(); end
    ext_evt = 1'b1;
    tick(); tick(); gv = 1'b1;
    for (int k = 0; k < 18; k++) begin check_model("R5 both gates"); tick(); end
    ext_strb = 1'b0;
    tick(); tick(); gh = 1'b0;
    for (int k = 0; k < 18; k++) begin check_model("R5 strobe low"); tick(); end
    en = 1'b0; ext_evt = 1'b0; h_gate_sel = 2'd0; v_gate_sel = 2'd0;
    gh = 1'b1; gv = 1'b1;
    tick();

    // R6 armed start on trigger
    sync_type = 2'd3; h_pol = 1'b0; v_pol = 1'b1;
    h_start_sel = 2'd3; v_start_sel = 2'd3;
    en = 1'b1;
    for (int k = 0; k < 10; k++) begin tick(); check_idle("R6 waiting"); end
    ext_trig = 1'b1;
    tick(); check_idle("R6 edge 1");
    tick(); check_idle("R6 edge 2");
    tick(); t = 0;
    for (int k = 0; k < 36; k++) begin check_model("R6 started"); tick(); end

    // R7 disable ignores qualifiers, re-arm needs a new edge
    en = 1'b0;
    tick(); check_idle("R7 off");
    for (int k = 0; k < 6; k++) begin
      ext_trig = ~ext_trig; ext_evt = ~ext_evt;
      tick(); check_idle("R7 qualifiers ignored");
    end
    ext_trig = 1'b1; ext_evt = 1'b0;
    tick(); tick(); tick();
    en = 1'b1;
    for (int k = 0; k < 12; k++) begin tick(); check_idle("R7 level does not restart"); end
    ext_trig = 1'b0;
    tick(); tick(); tick();
    ext_trig = 1'b1;
    tick(); tick(); tick(); t = 0;
    for (int k = 0; k < 36; k++) begin check_model("R7 restart on edge"); tick(); end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule